// File: doc/BRIEF.md
# Latched Analog Multiplexer Switch Gate Controller

This block is the digital control logic of a sixteen-input, two-level analog multiplexer. It drives the gates of the switch array and never touches the analog path. A four-bit channel address and three select qualifiers are captured whenever the strobe input is high. The captured values persist while the strobe is low. They are decoded into gate drives:

- Every input has a T-switch made of two series elements and one shunt-to-ground element.
- The inputs form two banks of eight.
- Each bank reaches the common output through its own series switch.

Moving from one channel to another passes through a break-before-make gap. During the gap every series element and both bank switches are open, and every shunt element is closed. The gap lasts `BBM_CYCLES` clock cycles. A status output reports whether a channel is currently connected. A parent block places one instance next to each analog switch array. It sequences inputs onto the shared output by writing an address and pulsing the strobe.

Top module: `amux_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, all series outputs and both bank outputs are 0, all shunt outputs are 1, and `sel_active` is 0.
- R2: With the combined enable true, address value n (`addr[3]` most significant) connects input n+1. That sets bit n of both `ser_a` and `ser_b`, and no other series bit.
- R3: `addr`, `en`, `cs_hi` and `cs_lo_n` are sampled only at rising edges where `strobe` is 1. Changes made while `strobe` is 0 leave every output unchanged.
- R4: The combined enable is `en`=1, `cs_hi`=1 and `cs_lo_n`=0, sampled together with the address. If any of the three disagrees, every series and bank output is 0 whatever the address.
- R5: For each channel, `ser_a` and `ser_b` are equal, and `shunt` is their inverse, in every cycle.
- R6: `bank_sw[0]` is 1 only while a channel with address 0 to 7 is connected. `bank_sw[1]` is 1 only while a channel with address 8 to 15 is connected. The two are never 1 together.
- R7: `sel_active` is 1 exactly when some channel is connected.
- R8: From the idle state with the gap expired, a request sampled at rising edge k connects its channel at edge k+1.
- R9: A request sampled at edge k that differs from the connected channel, or disables it, opens everything at edge k+1. Everything then stays open for exactly `BBM_CYCLES` cycles before any new channel is connected. Re-strobing the connected channel causes no break.
- R10: At most one channel's series pair is closed in any cycle. The design never moves directly from one closed channel to another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe | input | 1 | Capture enable for the address and qualifiers |
| addr | input | 4 | Channel address, value n selects input n+1 |
| en | input | 1 | Enable qualifier, active high |
| cs_hi | input | 1 | Chip select qualifier, active high |
| cs_lo_n | input | 1 | Chip select qualifier, active low |
| ser_a | output | 16 | Input-side series element gate per channel |
| ser_b | output | 16 | Output-side series element gate per channel |
| shunt | output | 16 | Shunt-to-ground element gate per channel |
| bank_sw | output | 2 | Second-level series switch per bank of eight |
| sel_active | output | 1 | Channel-connected status |

## Verification
Call the rising edge that samples a strobed request edge k.

- From idle, the new drive is due one edge later, at k+1.
- A change of channel keeps the old drive through edge k, opens everything at edge k+1, and closes the new channel at edge k+1+`BBM_CYCLES`.

The bench changes inputs on falling edges and reads outputs on the following falling edges. It counts falling edges from the strobe to each due cycle, and it compares every cycle of the gap, so a gap that is one cycle longer or shorter is caught. The enable sweep waits long enough for any gap to finish before comparing the settled drive of all five outputs.

// File: rtl/amux_pkg.sv
package amux_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ON   = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/amux_req_hold.sv
module amux_req_hold #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  output logic [AW-1:0] held_addr,
  output logic          held_on
);
  logic [AW-1:0] addr_nxt;
  logic          on_nxt;

  // Capture only while the strobe is high; otherwise hold.
  always_comb begin
    addr_nxt = held_addr;
    on_nxt   = held_on;
    if (strobe) begin
      addr_nxt = addr;
      on_nxt   = en & cs_hi & ~cs_lo_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_on   <= 1'b0;
    end else begin
      held_addr <= addr_nxt;
      held_on   <= on_nxt;
    end
  end
endmodule

// File: rtl/amux_bbm_seq.sv
module amux_bbm_seq
  import amux_pkg::*;
#(
  parameter int AW         = 4,
  parameter int BBM_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tgt_addr,
  input  logic          tgt_on,
  output logic          drv_on,
  output logic [AW-1:0] drv_addr
);
  localparam int GW = (BBM_CYCLES > 1) ? $clog2(BBM_CYCLES) : 1;
  localparam logic [GW-1:0] GAP_LOAD = GW'(BBM_CYCLES - 1);

  seq_state_t    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (tgt_on) begin
          st_d   = SQ_ON;
          addr_d = tgt_addr;
        end
      end
      SQ_ON: begin
        if (!tgt_on || (tgt_addr != addr_q)) begin
          st_d  = SQ_GAP;
          cnt_d = GAP_LOAD;
        end
      end
      SQ_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - GW'(1);
        end else if (tgt_on) begin
          st_d   = SQ_ON;
          addr_d = tgt_addr;
        end else begin
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign drv_on   = (st_q == SQ_ON);
  assign drv_addr = addr_q;
endmodule

// File: rtl/amux_gate_decode.sv
module amux_gate_decode #(
  parameter int NUM_CH = 16
) (
  input  logic                      drv_on,
  input  logic [$clog2(NUM_CH)-1:0] drv_addr,
  output logic [NUM_CH-1:0]         ser_a,
  output logic [NUM_CH-1:0]         ser_b,
  output logic [NUM_CH-1:0]         shunt,
  output logic [1:0]                bank_sw,
  output logic                      sel_active
);
  localparam int AW      = $clog2(NUM_CH);
  localparam int BANK_SZ = NUM_CH / 2;

  logic [NUM_CH-1:0] ch_on;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_tsw
    assign ch_on[i] = drv_on && (drv_addr == AW'(i));
    assign ser_a[i] = ch_on[i];
    assign ser_b[i] = ch_on[i];
    assign shunt[i] = ~ch_on[i];
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_sw[b] = |ch_on[b*BANK_SZ +: BANK_SZ];
  end

  assign sel_active = drv_on;
endmodule

// File: rtl/amux_gate_ctrl.sv
module amux_gate_ctrl #(
  parameter int NUM_CH     = 16,
  parameter int BBM_CYCLES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe,
  input  logic [$clog2(NUM_CH)-1:0] addr,
  input  logic                      en,
  input  logic                      cs_hi,
  input  logic                      cs_lo_n,
  output logic [NUM_CH-1:0]         ser_a,
  output logic [NUM_CH-1:0]         ser_b,
  output logic [NUM_CH-1:0]         shunt,
  output logic [1:0]                bank_sw,
  output logic                      sel_active
);
  localparam int AW = $clog2(NUM_CH);

  logic [AW-1:0] held_addr, drv_addr;
  logic          held_on, drv_on;

  amux_req_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr),
    .en(en), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .held_addr(held_addr), .held_on(held_on)
  );

  amux_bbm_seq #(.AW(AW), .BBM_CYCLES(BBM_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgt_addr(held_addr), .tgt_on(held_on),
    .drv_on(drv_on), .drv_addr(drv_addr)
  );

  amux_gate_decode #(.NUM_CH(NUM_CH)) u_dec (
    .drv_on(drv_on), .drv_addr(drv_addr),
    .ser_a(ser_a), .ser_b(ser_b), .shunt(shunt),
    .bank_sw(bank_sw), .sel_active(sel_active)
  );
endmodule

// File: rtl/amux_gate_chk.sv
module amux_gate_chk #(
  parameter int NUM_CH     = 16,
  parameter int BBM_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic              en,
  input logic              cs_hi,
  input logic              cs_lo_n,
  input logic [NUM_CH-1:0] ser_a,
  input logic [NUM_CH-1:0] ser_b,
  input logic [NUM_CH-1:0] shunt,
  input logic [1:0]        bank_sw,
  input logic              sel_active
);
  localparam int HALF = NUM_CH / 2;
  localparam int RW   = $clog2(BBM_CYCLES + 1) + 1;

  logic          had_on;
  logic [RW-1:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      had_on  <= 1'b0;
      off_run <= '0;
    end else begin
      if (|ser_a) had_on <= 1'b1;
      if (|ser_a) off_run <= '0;
      else if (off_run < RW'(BBM_CYCLES)) off_run <= off_run + RW'(1);
    end
  end

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_a));

  assert_no_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ser_a) && (|$past(ser_a))) |-> (ser_a == $past(ser_a)));

  assert_tee_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_a == ser_b) && (shunt == ~ser_a));

  assert_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sw) && (bank_sw[0] == |ser_a[HALF-1:0])
    && (bank_sw[1] == |ser_a[NUM_CH-1:HALF]));

  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_active == (|ser_a));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ser_a) && had_on && (off_run != '0)) |-> (off_run >= RW'(BBM_CYCLES)));

  assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(en && cs_hi && !cs_lo_n)) |=> ##1 (ser_a == '0));
endmodule

bind amux_gate_ctrl amux_gate_chk #(.NUM_CH(NUM_CH), .BBM_CYCLES(BBM_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .en(en), .cs_hi(cs_hi),
  .cs_lo_n(cs_lo_n), .ser_a(ser_a), .ser_b(ser_b), .shunt(shunt),
  .bank_sw(bank_sw), .sel_active(sel_active)
);

// File: tb/sim_amux_gate_ctrl.sv
module sim_amux_gate_ctrl;
  localparam int NUM_CH = 16;
  localparam int BBM    = 2;

  logic              clk = 1'b0;
  logic              rst_n, strobe, en, cs_hi, cs_lo_n;
  logic [3:0]        addr;
  logic [NUM_CH-1:0] ser_a, ser_b, shunt;
  logic [1:0]        bank_sw;
  logic              sel_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  amux_gate_ctrl #(.NUM_CH(NUM_CH), .BBM_CYCLES(BBM)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .en(en),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .ser_a(ser_a), .ser_b(ser_b),
    .shunt(shunt), .bank_sw(bank_sw), .sel_active(sel_active)
  );

  // Expected drive word {ser_a, ser_b, shunt, bank_sw, sel_active}.
  function automatic logic [3*NUM_CH+2:0] expect_word(input bit on, input int idx);
    logic [NUM_CH-1:0] s;
    logic [1:0]        b;
    s = on ? (NUM_CH'(1) << idx) : '0;
    b = on ? ((idx >= NUM_CH/2) ? 2'b10 : 2'b01) : 2'b00;
    return {s, s, ~s, b, on};
  endfunction

  task automatic check(input bit on, input int idx, input string req);
    logic [3*NUM_CH+2:0] act, exp;
    act = {ser_a, ser_b, shunt, bank_sw, sel_active};
    exp = expect_word(on, idx);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Present a request with the strobe high for one rising edge; returns at
  // the falling edge just after that sampling edge.
  task automatic request(input int a, input bit e, input bit ch, input bit cl);
    @(negedge clk);
    addr = 4'(a); en = e; cs_hi = ch; cs_lo_n = cl; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic settle();
    repeat (BBM + 4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; strobe = 1'b0; addr = '0; en = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, 0, "R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, 0, "R1 after reset");

    // R8: from idle the channel closes one edge after the sampling edge.
    request(5, 1'b1, 1'b1, 1'b0);
    check(1'b0, 0, "R8 not yet at sampling edge");
    @(negedge clk);
    check(1'b1, 5, "R8 on at next edge");

    // R3: changes with the strobe low are ignored.
    @(negedge clk);
    addr = 4'd9; en = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1;
    repeat (BBM + 3) @(negedge clk);
    check(1'b1, 5, "R3 strobe low ignored");

    // R9: break-before-make from channel 3 to channel 12.
    request(3, 1'b1, 1'b1, 1'b0);
    settle();
    check(1'b1, 3, "R9 start on 3");
    request(12, 1'b1, 1'b1, 1'b0);
    check(1'b1, 3, "R9 old held at sampling edge");
    for (int i = 0; i < BBM; i++) begin
      @(negedge clk);
      check(1'b0, 0, "R9 gap cycle");
    end
    @(negedge clk);
    check(1'b1, 12, "R9 new on after gap");

    // R9: re-strobing the same channel causes no break.
    request(12, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < BBM + 2; i++) begin
      @(negedge clk);
      check(1'b1, 12, "R9 same channel no break");
    end

    // R4/R9: disable opens everything one edge after sampling.
    request(12, 1'b0, 1'b1, 1'b0);
    check(1'b1, 12, "R4 held at sampling edge");
    @(negedge clk);
    check(1'b0, 0, "R4 off after disable");

    // R2/R4/R6/R7: sweep all qualifier combinations and addresses.
    for (int q = 0; q < 8; q++) begin
      for (int a = 0; a < NUM_CH; a++) begin
        bit e, ch, cl, on;
        e = q[2]; ch = q[1]; cl = q[0];
        on = e && ch && !cl;
        request(a, e, ch, cl);
        settle();
        check(on, a, on ? "R2 R6 R7 selected drive" : "R4 qualifier off");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule